// File: doc/BRIEF.md
# Adaptive Engine Clock-Gating Controller

This controller decides how many packet-processing engines keep a running clock. On each sample strobe it looks at two pressure indicators: the depth of the pending-thread queue and a flag that reports a full receive buffer. A saturating pressure counter grows by one in every sample where the queue depth is above a programmable limit. When that count rises above an adaptive threshold, one engine is retired. A full buffer brings one engine back. The threshold tunes itself: every retirement lowers it by a programmable step, and every wake-up raises it by the same step. It is held between a configured floor and ceiling.

An engine is never switched off in the middle of work. The controller first asks the engine to drain its threads, naming the engine on `drain_pe_o`. The engine's enable bit stays set until the drain acknowledge arrives. A gated engine keeps its instruction store, so it can be woken in a single step with no reload. The per-engine enable mask drives the clock-gate cells, which sit outside this block.

Top module: `pe_gate_ctrl`

## Requirements
- R1: After reset all NUM_PE enable bits are 1, no drain is requested, the pressure count is 0 and the threshold is THR_INIT.
- R2: In a sample (sample_i=1) without buf_full_i, the pressure count rises by one (saturating at all ones) only if qlen_i is strictly greater than qlen_limit_i; a depth equal to the limit leaves it unchanged.
- R3: If the count after that increment is greater than the threshold, no drain is outstanding and at least two engines are enabled, then on the next cycle drain_req_o is 1 and drain_pe_o names the highest-index enabled engine; the count returns to 0 and the threshold drops by step_i, but not below thr_min_i.
- R4: The enable bit of the draining engine stays 1 until drain_done_i is seen high while drain_req_o is 1; on that edge the bit clears and drain_req_o returns to 0.
- R5: A sample with buf_full_i=1 sets the lowest-index cleared enable bit (if any) on the next cycle, clears the count and raises the threshold by step_i, but not above thr_max_i; in that sample no retirement starts, even if the count would have passed the threshold.
- R6: While a drain is outstanding a further retirement trigger starts no new drain and does not change drain_pe_o; the count keeps accumulating.
- R7: The enable mask is never all zero; a retirement trigger with only one engine enabled does nothing.
- R8: drain_done_i while no drain is outstanding has no effect on the enable mask or on the drain request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sample_i | input | 1 | Sample strobe for the pressure inputs |
| qlen_i | input | QLEN_W | Pending-thread queue depth |
| buf_full_i | input | 1 | Receive buffer full |
| qlen_limit_i | input | QLEN_W | Depth above which a sample counts as pressure |
| step_i | input | CNT_W | Threshold adjustment step |
| thr_min_i | input | CNT_W | Threshold floor |
| thr_max_i | input | CNT_W | Threshold ceiling |
| drain_done_i | input | 1 | Engine under drain has finished its threads |
| pe_en_o | output | NUM_PE | Per-engine clock enable |
| drain_req_o | output | 1 | A drain is outstanding |
| drain_pe_o | output | PE_IDX_W | Index of the engine being drained |

## Verification
The bench targets several corner cases. A depth exactly at the limit must not count; an off-by-one compare would retire engines one sample early. A full buffer in the same sample as an over-threshold count must wake an engine and not retire one; reversed priority would retire an engine just as traffic backs up. With a drain pending, further triggers must not retarget it; with one engine left, a trigger must be dropped. A design that ignores either rule would switch off an engine that still holds threads, or end with an all-zero mask. The bench also drives the threshold into its floor and ceiling, and it gives acknowledges while no drain is pending. A wrong clamp shows as shifted retirement timing; a stray acknowledge that is not ignored clears an enable bit.

// File: rtl/pe_gate_pkg.sv
package pe_gate_pkg;
  // Kind of controller event decided in one sample
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_WAKE = 2'd1,
    EV_SHUT = 2'd2
  } pe_event_e;
endpackage

// File: rtl/pe_pressure_track.sv
module pe_pressure_track
  import pe_gate_pkg::*;
#(
  parameter int QLEN_W   = 6,
  parameter int CNT_W    = 6,
  parameter int THR_INIT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_i,
  input  logic [QLEN_W-1:0] qlen_i,
  input  logic              buf_full_i,
  input  logic [QLEN_W-1:0] qlen_limit_i,
  input  logic [CNT_W-1:0]  step_i,
  input  logic [CNT_W-1:0]  thr_min_i,
  input  logic [CNT_W-1:0]  thr_max_i,
  input  logic              shut_ok_i,
  output pe_event_e         event_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, thr_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             hit, over, wake_ev, shut_ev;

  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] c, input logic en);
    return (en && c != CNT_TOP) ? c + 1'b1 : c;
  endfunction

  function automatic logic [CNT_W-1:0] thr_raise(input logic [CNT_W-1:0] t,
                                                 input logic [CNT_W-1:0] s,
                                                 input logic [CNT_W-1:0] hi);
    logic [CNT_W:0] sum;
    sum = {1'b0, t} + {1'b0, s};
    return (sum > {1'b0, hi}) ? hi : sum[CNT_W-1:0];
  endfunction

  function automatic logic [CNT_W-1:0] thr_lower(input logic [CNT_W-1:0] t,
                                                 input logic [CNT_W-1:0] s,
                                                 input logic [CNT_W-1:0] lo);
    logic [CNT_W:0] floor_sum;
    floor_sum = {1'b0, lo} + {1'b0, s};
    return ({1'b0, t} < floor_sum) ? lo : t - s;
  endfunction

  assign hit     = qlen_i > qlen_limit_i;
  assign cnt_inc = sat_inc(cnt_q, hit);
  assign over    = cnt_inc > thr_q;
  assign wake_ev = sample_i && buf_full_i;
  assign shut_ev = sample_i && !buf_full_i && over && shut_ok_i;
  assign event_o = wake_ev ? EV_WAKE : (shut_ev ? EV_SHUT : EV_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      thr_q <= CNT_W'(THR_INIT);
    end else if (wake_ev) begin
      cnt_q <= '0;
      thr_q <= thr_raise(thr_q, step_i, thr_max_i);
    end else if (shut_ev) begin
      cnt_q <= '0;
      thr_q <= thr_lower(thr_q, step_i, thr_min_i);
    end else if (sample_i) begin
      cnt_q <= cnt_inc;
    end
  end

  AST_WAKE_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ev |-> !shut_ev); // R5
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_ev || shut_ev) |=> cnt_q == '0); // R3
  AST_THR_UP: assert property (@(posedge clk) disable iff (!rst_n)
    wake_ev |=> (thr_q >= $past(thr_q)) || (thr_q == $past(thr_max_i))); // R5
  AST_THR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    shut_ev |=> (thr_q <= $past(thr_q)) || (thr_q == $past(thr_min_i))); // R3
  AST_CNT_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_i && !wake_ev && !shut_ev) |=> cnt_q >= $past(cnt_q)); // R2
endmodule

// File: rtl/pe_pick.sv
module pe_pick #(
  parameter int NUM_PE   = 8,
  parameter int PE_IDX_W = $clog2(NUM_PE),
  parameter int ONES_W   = $clog2(NUM_PE + 1)
) (
  input  logic [NUM_PE-1:0]   mask_i,
  output logic [PE_IDX_W-1:0] lo_off_o,
  output logic                lo_off_vld_o,
  output logic [PE_IDX_W-1:0] hi_on_o,
  output logic [ONES_W-1:0]   ones_o
);
  always_comb begin
    lo_off_o     = '0;
    lo_off_vld_o = 1'b0;
    for (int i = NUM_PE - 1; i >= 0; i--) begin
      if (!mask_i[i]) begin
        lo_off_o     = PE_IDX_W'(i);
        lo_off_vld_o = 1'b1;
      end
    end
  end

  always_comb begin
    hi_on_o = '0;
    ones_o  = '0;
    for (int i = 0; i < NUM_PE; i++) begin
      if (mask_i[i]) begin
        hi_on_o = PE_IDX_W'(i);
        ones_o  = ones_o + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pe_gate_ctrl.sv
module pe_gate_ctrl
  import pe_gate_pkg::*;
#(
  parameter int NUM_PE   = 8,
  parameter int QLEN_W   = 6,
  parameter int CNT_W    = 6,
  parameter int THR_INIT = 8,
  parameter int PE_IDX_W = $clog2(NUM_PE)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_i,
  input  logic [QLEN_W-1:0]   qlen_i,
  input  logic                buf_full_i,
  input  logic [QLEN_W-1:0]   qlen_limit_i,
  input  logic [CNT_W-1:0]    step_i,
  input  logic [CNT_W-1:0]    thr_min_i,
  input  logic [CNT_W-1:0]    thr_max_i,
  input  logic                drain_done_i,
  output logic [NUM_PE-1:0]   pe_en_o,
  output logic                drain_req_o,
  output logic [PE_IDX_W-1:0] drain_pe_o
);
  localparam int ONES_W = $clog2(NUM_PE + 1);

  logic [NUM_PE-1:0]   en_q, en_d;
  logic                drain_q, drain_d;
  logic [PE_IDX_W-1:0] drain_idx_q, drain_idx_d;
  logic [PE_IDX_W-1:0] lo_off, hi_on;
  logic                lo_off_vld;
  logic [ONES_W-1:0]   ones;
  logic                shut_ok, drain_ack;
  pe_event_e           ev;

  pe_pick #(.NUM_PE(NUM_PE), .PE_IDX_W(PE_IDX_W), .ONES_W(ONES_W)) pick_i (
    .mask_i       (en_q),
    .lo_off_o     (lo_off),
    .lo_off_vld_o (lo_off_vld),
    .hi_on_o      (hi_on),
    .ones_o       (ones)
  );

  assign shut_ok   = !drain_q && (ones >= ONES_W'(2));
  assign drain_ack = drain_q && drain_done_i;

  pe_pressure_track #(.QLEN_W(QLEN_W), .CNT_W(CNT_W), .THR_INIT(THR_INIT)) press_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .sample_i     (sample_i),
    .qlen_i       (qlen_i),
    .buf_full_i   (buf_full_i),
    .qlen_limit_i (qlen_limit_i),
    .step_i       (step_i),
    .thr_min_i    (thr_min_i),
    .thr_max_i    (thr_max_i),
    .shut_ok_i    (shut_ok),
    .event_o      (ev)
  );

  always_comb begin
    en_d        = en_q;
    drain_d     = drain_q;
    drain_idx_d = drain_idx_q;
    if (drain_ack) begin
      en_d[drain_idx_q] = 1'b0;
      drain_d           = 1'b0;
    end
    if (ev == EV_WAKE && lo_off_vld) en_d[lo_off] = 1'b1;
    if (ev == EV_SHUT) begin
      drain_d     = 1'b1;
      drain_idx_d = hi_on;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q        <= '1;
      drain_q     <= 1'b0;
      drain_idx_q <= '0;
    end else begin
      en_q        <= en_d;
      drain_q     <= drain_d;
      drain_idx_q <= drain_idx_d;
    end
  end

  assign pe_en_o     = en_q;
  assign drain_req_o = drain_q;
  assign drain_pe_o  = drain_idx_q;

  AST_ONE_ALIVE: assert property (@(posedge clk) disable iff (!rst_n)
    en_q != '0); // R7
  AST_DRAIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    drain_q |-> en_q[drain_idx_q]); // R4
  AST_NO_SILENT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !drain_ack |=> $countones(en_q) >= $countones($past(en_q))); // R4
  AST_ONE_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_q && !drain_done_i) |=> drain_q && $stable(drain_idx_q)); // R6
  AST_STRAY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!drain_q && ev != EV_SHUT) |=> !drain_q); // R8
endmodule

// File: tb/pe_gate_ctrl_tb.sv
module pe_gate_ctrl_tb_top;
  localparam int NPE = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sample_i = 1'b0, buf_full_i = 1'b0, drain_done_i = 1'b0;
  logic [5:0] qlen_i = '0, qlen_limit_i = 6'd4;
  logic [5:0] step_i = 6'd2, thr_min_i = 6'd2, thr_max_i = 6'd12;
  logic [NPE-1:0] pe_en_o;
  logic       drain_req_o;
  logic [2:0] drain_pe_o;

  int checks = 0, errors = 0;
  string cur_req = "R1";
  bit done_flag = 1'b0;

  // reference model state
  logic [NPE-1:0] m_en;
  bit  m_drain;
  int  m_pe, m_cnt, m_thr;

  pe_gate_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .qlen_i(qlen_i),
    .buf_full_i(buf_full_i), .qlen_limit_i(qlen_limit_i), .step_i(step_i),
    .thr_min_i(thr_min_i), .thr_max_i(thr_max_i), .drain_done_i(drain_done_i),
    .pe_en_o(pe_en_o), .drain_req_o(drain_req_o), .drain_pe_o(drain_pe_o)
  );

  always #4 clk = ~clk;

  // Behavioural reference, decisions taken from the state before the edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = '1; m_drain = 0; m_pe = 0; m_cnt = 0; m_thr = 8;
    end else begin
      logic [NPE-1:0] old_en;
      bit old_drain;
      int enabled, lowest_off, highest_on, c2;
      old_en = m_en; old_drain = m_drain;
      enabled = 0; lowest_off = -1; highest_on = 0;
      for (int k = 0; k < NPE; k++) begin
        if (old_en[k]) begin enabled++; highest_on = k; end
        else if (lowest_off < 0) lowest_off = k;
      end
      if (old_drain && drain_done_i) begin m_en[m_pe] = 1'b0; m_drain = 0; end
      if (sample_i) begin
        if (buf_full_i) begin
          if (lowest_off >= 0) m_en[lowest_off] = 1'b1;
          m_cnt = 0;
          m_thr = (m_thr + int'(step_i) > int'(thr_max_i)) ? int'(thr_max_i) : m_thr + int'(step_i);
        end else begin
          c2 = m_cnt + ((qlen_i > qlen_limit_i) ? 1 : 0);
          if (c2 > 63) c2 = 63;
          if (c2 > m_thr && !old_drain && enabled >= 2) begin
            m_drain = 1; m_pe = highest_on; m_cnt = 0;
            m_thr = (m_thr - int'(step_i) < int'(thr_min_i)) ? int'(thr_min_i) : m_thr - int'(step_i);
          end else m_cnt = c2;
        end
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done_flag) begin
      checks++;
      if (pe_en_o !== m_en || drain_req_o !== m_drain || (m_drain && drain_pe_o !== 3'(m_pe))) begin
        errors++;
        $display("FAIL %s: en=%b req=%0b pe=%0d expected en=%b req=%0b pe=%0d",
                 cur_req, pe_en_o, drain_req_o, drain_pe_o, m_en, m_drain, m_pe);
      end
    end
  end

  task automatic cyc(input bit s, input int q, input bit full, input bit done);
    @(negedge clk);
    sample_i = s; qlen_i = 6'(q); buf_full_i = full; drain_done_i = done;
  endtask

  task automatic expect_now(input string req, input logic [NPE-1:0] en, input bit req_v, input int pe);
    @(negedge clk);
    checks++;
    if (pe_en_o !== en || drain_req_o !== req_v || (req_v && drain_pe_o !== 3'(pe))) begin
      errors++;
      $display("FAIL %s: en=%b req=%0b pe=%0d expected en=%b req=%0b pe=%0d",
               req, pe_en_o, drain_req_o, drain_pe_o, en, req_v, pe);
    end
  endtask

  task automatic finish_run();
    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_now("R1", 8'hFF, 0, 0);

    // R2: depth equal to limit never counts; 8 hits stay at threshold 8
    cur_req = "R2";
    repeat (5) cyc(1, 4, 0, 0);
    repeat (8) cyc(1, 5, 0, 0);
    cyc(1, 4, 0, 0);
    cyc(0, 0, 0, 0);
    expect_now("R2", 8'hFF, 0, 0);
    // R3: ninth hit passes threshold 8, highest engine named
    cur_req = "R3";
    cyc(1, 9, 0, 0);
    cyc(0, 0, 0, 0);
    expect_now("R3", 8'hFF, 1, 7);
    // R6: more triggers while draining start nothing new
    cur_req = "R6";
    repeat (12) cyc(1, 20, 0, 0);
    cyc(0, 0, 0, 0);
    expect_now("R6", 8'hFF, 1, 7);
    // R4: acknowledge clears the bit
    cur_req = "R4";
    cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 0);
    expect_now("R4", 8'h7F, 0, 0);
    // R8: stray acknowledges have no effect
    cur_req = "R8";
    repeat (3) cyc(0, 0, 0, 1);
    cyc(0, 0, 0, 0);
    expect_now("R8", 8'h7F, 0, 0);
    // R3 / R7: keep pressure up, acknowledge promptly, down to one engine
    cur_req = "R7";
    for (int i = 0; i < 120; i++) cyc(1, 30, 0, drain_req_o);
    cyc(0, 0, 0, 0);
    expect_now("R7", 8'h01, 0, 0);
    // R5: full buffer wakes lowest cleared engine
    cur_req = "R5";
    cyc(1, 0, 1, 0);
    cyc(0, 0, 0, 0);
    expect_now("R5", 8'h03, 0, 0);
    // R5: full and over-threshold in same sample -> wake wins
    repeat (30) cyc(1, 30, 0, 0);
    cyc(0, 0, 0, drain_req_o);
    cyc(0, 0, 0, 0);
    repeat (3) cyc(1, 30, 1, 0);
    cyc(0, 0, 0, 0);
    expect_now("R5", 8'h0F, 0, 0);
    repeat (10) cyc(1, 0, 1, 0);
    cyc(0, 0, 0, 0);
    expect_now("R5", 8'hFF, 0, 0);
    // mixed traffic, threshold driven into both clamps
    cur_req = "R3";
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0] | lfsr[1], int'(lfsr[7:2]) % 10, lfsr[11:8] == 4'h0,
          lfsr[12] | (lfsr[13] & !drain_req_o));
    end
    cyc(0, 0, 0, 0);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule